// File: doc/BRIEF.md
# UART Buffering and Interrupt Logic

This block sits between a UART's bit-level shifters and a 32-bit register bus. It buffers outgoing bytes in a transmit queue and incoming characters, each with its error flags, in a receive queue. Both queues are first-in first-out. It raises interrupt flags when a queue's fill level crosses a level picked by software, when received data has sat unread for too long, and when the receiver reports line errors or a lost character.

The serial side is a plain push/pop interface. The transmitter sees `tx_valid`/`tx_data` and pulses `tx_pop` to take a byte. The receiver pulses `rx_push` with a byte and three error flags. A `bit_tick` strobe, once per bit period, drives the idle timer. Software reads status, programs the thresholds and the interrupt enables, and acknowledges flags by writing ones. The bus reads combinationally in the cycle `bus_sel` is high; writes and read side effects take place at the next clock edge.

Registers are word offsets on `bus_addr[4:2]`: 0 data, 1 status, 2 level select, 3 enable mask, 4 raw flags, 5 masked flags, 6 clear. Offset 6 and offset 7 read as zero.

Top module: `uart_fifo_irq`

## Requirements
- R1: Each queue holds DEPTH (16) entries and returns them in arrival order. A read of offset 0 pops one receive entry and returns the byte in bits 7:0, framing error in bit 8, parity error in bit 9, break in bit 10 and overrun mark in bit 11. A read of offset 0 on an empty receive queue returns 0 and changes nothing.
- R2: The status register at offset 1 reads bit 7 = transmit queue empty, bit 6 = receive queue full, bit 5 = transmit queue full, bit 4 = receive queue empty, and bit 3 = busy. Busy is `tx_busy` OR transmit queue non-empty. All other bits read 0.
- R3: Level register bits 5:3 hold the receive code. Codes 0,1,2,3,4 set raw bit 4 when the receive fill goes from 1 to 2, 3 to 4, 7 to 8, 11 to 12 or 13 to 14. Codes 5 to 7 act as code 4.
- R4: Level register bits 2:0 hold the transmit code. Codes 0,1,2,3,4 set raw bit 5 when the transmit fill drops from 15 to 14, 13 to 12, 9 to 8, 5 to 4 or 3 to 2. Codes 5 to 7 act as code 4.
- R5: Raw bit 6 sets when the receive queue has held data for 32 `bit_tick` strobes with no `rx_push` and no data-register read. Either of those events, or an empty queue, restarts the count.
- R6: An `rx_push` while the receive queue is full is discarded and sets raw bit 10. The next accepted entry carries the overrun mark in bit 11.
- R7: An accepted `rx_push` with `rx_err[0]` (framing), `rx_err[1]` (parity) or `rx_err[2]` (break) sets raw bit 7, 8 or 9 respectively.
- R8: Writing offset 6 clears each raw flag whose bit is 1 in the write data; 0 bits have no effect. A flag being set in the same cycle wins over its clear.
- R9: Offset 3 holds the enable mask for bits 10:4. Offset 5 reads the raw flags ANDed with the mask, and `irq` is high exactly when any masked flag is set.
- R10: A data-register write pushes bits 7:0 into the transmit queue unless it is full, in which case it is ignored. `tx_valid`/`tx_data` present the oldest byte, and `tx_pop` on an empty queue is ignored.
- R11: After reset both queues are empty, all flags, mask and level codes are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits 4:2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_pop | input | 1 | Transmitter takes the oldest byte |
| tx_busy | input | 1 | Transmitter is shifting a character |
| rx_push | input | 1 | Receiver delivers a character |
| rx_data | input | 8 | Received byte |
| rx_err | input | 3 | {break, parity, framing} for the delivered byte |
| bit_tick | input | 1 | One strobe per bit period |
| irq | output | 1 | Combined interrupt request |

## Verification
Every cycle, the embedded properties check four things. The receive count never exceeds its depth. A discarded push always raises the overrun flag. A write to a full transmit queue leaves it full. Rising edges of the idle flag appear only with data waiting. The properties also tie an upward crossing of the receive threshold to its flag, and a write-one clear of that flag with no push to its removal. Only the bench's scenarios can show the rest: arrival order through both queues, the overrun mark landing on the following entry, the exact 32-strobe idle window and its restarts, the five crossing points per direction, and the masked view and `irq` following mask changes. A reference model tracks these over directed sequences and a long random mix.

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq #(
  parameter int DEPTH     = 16,
  parameter int IDLE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_pop,
  input  logic        tx_busy,
  input  logic        rx_push,
  input  logic [7:0]  rx_data,
  input  logic [2:0]  rx_err,
  input  logic        bit_tick,
  output logic        irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int TW = $clog2(IDLE_BITS + 1);
  localparam logic [2:0] OFS_DATA = 3'd0, OFS_STAT = 3'd1, OFS_LVL = 3'd2,
                         OFS_MASK = 3'd3, OFS_RAW  = 3'd4, OFS_MIS = 3'd5,
                         OFS_CLR  = 3'd6;

  function automatic logic [CW-1:0] level_of(input logic [2:0] k);
    case (k)
      3'd0:    level_of = CW'(DEPTH / 8);
      3'd1:    level_of = CW'(DEPTH / 4);
      3'd2:    level_of = CW'(DEPTH / 2);
      3'd3:    level_of = CW'((3 * DEPTH) / 4);
      default: level_of = CW'((7 * DEPTH) / 8);
    endcase
  endfunction

  logic [7:0]    txm [DEPTH];
  logic [11:0]   rxm [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [TW-1:0] idle_cnt;
  logic [5:0]    lvl;
  logic [6:0]    raw7, mask7;
  logic          ovr_mark;

  wire [2:0] ofs     = bus_addr[4:2];
  wire       wr_en   = bus_sel & bus_wr;
  wire       rd_data = bus_sel & ~bus_wr & (ofs == OFS_DATA);
  wire       wr_data = wr_en & (ofs == OFS_DATA);
  wire       clr_wr  = wr_en & (ofs == OFS_CLR);

  wire tx_full  = (tx_cnt == CW'(DEPTH));
  wire rx_full  = (rx_cnt == CW'(DEPTH));
  wire tx_empty = (tx_cnt == '0);
  wire rx_empty = (rx_cnt == '0);

  wire tx_in  = wr_data & ~tx_full;
  wire tx_out = tx_pop & ~tx_empty;
  wire rx_in  = rx_push & ~rx_full;
  wire rx_drop = rx_push & rx_full;
  wire rx_out = rd_data & ~rx_empty;

  wire [CW-1:0] tx_cnt_n = tx_cnt + CW'(tx_in) - CW'(tx_out);
  wire [CW-1:0] rx_cnt_n = rx_cnt + CW'(rx_in) - CW'(rx_out);

  wire [2:0]    tx_code = lvl[2:0];
  wire [2:0]    tx_k    = (tx_code >= 3'd4) ? 3'd0 : 3'd4 - tx_code;
  wire [CW-1:0] rx_thr  = level_of(lvl[5:3]);
  wire [CW-1:0] tx_thr  = level_of(tx_k);

  wire restart  = rx_push | rx_out;
  wire idle_hit = ~restart & ~rx_empty & bit_tick & (idle_cnt == TW'(IDLE_BITS - 1));

  logic [6:0] set7;
  always_comb begin
    set7    = '0;
    set7[0] = (rx_cnt < rx_thr) && (rx_cnt_n >= rx_thr);
    set7[1] = (tx_cnt > tx_thr) && (tx_cnt_n <= tx_thr);
    set7[2] = idle_hit;
    set7[3] = rx_in & rx_err[0];
    set7[4] = rx_in & rx_err[1];
    set7[5] = rx_in & rx_err[2];
    set7[6] = rx_drop;
  end

  wire [6:0] clr7 = clr_wr ? bus_wdata[10:4] : 7'd0;

  always_ff @(posedge clk) begin
    if (tx_in) txm[tx_wp] <= bus_wdata[7:0];
    if (rx_in) rxm[rx_wp] <= {ovr_mark, rx_err, rx_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
      tx_cnt <= '0; rx_cnt <= '0; idle_cnt <= '0;
      lvl <= '0; raw7 <= '0; mask7 <= '0; ovr_mark <= 1'b0;
    end else begin
      if (tx_in)  tx_wp <= tx_wp + 1'b1;
      if (tx_out) tx_rp <= tx_rp + 1'b1;
      if (rx_in)  rx_wp <= rx_wp + 1'b1;
      if (rx_out) rx_rp <= rx_rp + 1'b1;
      tx_cnt <= tx_cnt_n;
      rx_cnt <= rx_cnt_n;
      if (rx_drop)    ovr_mark <= 1'b1;
      else if (rx_in) ovr_mark <= 1'b0;
      if (restart || rx_empty)                            idle_cnt <= '0;
      else if (bit_tick && idle_cnt != TW'(IDLE_BITS))    idle_cnt <= idle_cnt + 1'b1;
      if (wr_en && ofs == OFS_LVL)  lvl   <= bus_wdata[5:0];
      if (wr_en && ofs == OFS_MASK) mask7 <= bus_wdata[10:4];
      raw7 <= (raw7 & ~clr7) | set7;
    end
  end

  assign tx_valid = ~tx_empty;
  assign tx_data  = txm[tx_rp];
  assign irq      = |(raw7 & mask7);

  always_comb begin
    case (ofs)
      OFS_DATA: bus_rdata = rx_empty ? 32'd0 : {20'd0, rxm[rx_rp]};
      OFS_STAT: bus_rdata = {24'd0, tx_empty, rx_full, tx_full, rx_empty,
                             tx_busy | ~tx_empty, 3'd0};
      OFS_LVL:  bus_rdata = {26'd0, lvl};
      OFS_MASK: bus_rdata = {21'd0, mask7, 4'd0};
      OFS_RAW:  bus_rdata = {21'd0, raw7, 4'd0};
      OFS_MIS:  bus_rdata = {21'd0, raw7 & mask7, 4'd0};
      default:  bus_rdata = 32'd0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31:11], bus_addr[1:0]};

  assert_rx_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));

  assert_rx_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_full && !rd_data && rx_cnt == rx_thr - CW'(1)) |=> raw7[0]);

  assert_idle_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw7[2]) |-> $past(rx_cnt) != '0);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> raw7[6]);

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && bus_wdata[4] && !rx_push) |=> !raw7[0]);

  assert_tx_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_full && !tx_pop) |=> tx_cnt == CW'(DEPTH));
endmodule

// File: tb/uart_fifo_irq_test.sv
module uart_fifo_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_pop = 1'b0, tx_busy = 1'b0;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [2:0]  rx_err = '0;
  logic        bit_tick = 1'b0;
  logic        irq;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  logic [11:0] m_rxq[$];
  logic [7:0]  m_txq[$];
  logic [6:0]  m_raw = '0, m_mask = '0;
  logic [5:0]  m_lvl = '0;
  int          m_idle = 0;
  bit          m_ovr = 0;

  always #2 clk = ~clk;

  uart_fifo_irq uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop), .tx_busy(tx_busy),
    .rx_push(rx_push), .rx_data(rx_data), .rx_err(rx_err),
    .bit_tick(bit_tick), .irq(irq));

  function automatic int rx_level(input logic [2:0] c);
    case (c)
      3'd0: return 2;   3'd1: return 4;   3'd2: return 8;
      3'd3: return 12;  default: return 14;
    endcase
  endfunction

  function automatic int tx_level(input logic [2:0] c);
    case (c)
      3'd0: return 14;  3'd1: return 12;  3'd2: return 8;
      3'd3: return 4;   default: return 2;
    endcase
  endfunction

  function automatic logic [31:0] expect_read(input logic [2:0] ofs);
    case (ofs)
      3'd0: return (m_rxq.size() != 0) ? {20'd0, m_rxq[0]} : 32'd0;
      3'd1: return {24'd0, m_txq.size() == 0, m_rxq.size() == 16, m_txq.size() == 16,
                    m_rxq.size() == 0, tx_busy || m_txq.size() != 0, 3'd0};
      3'd2: return {26'd0, m_lvl};
      3'd3: return {21'd0, m_mask, 4'd0};
      3'd4: return {21'd0, m_raw, 4'd0};
      3'd5: return {21'd0, m_raw & m_mask, 4'd0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int rxc = m_rxq.size();
    int txc = m_txq.size();
    bit rdpop = bus_sel && !bus_wr && bus_addr[4:2] == 3'd0 && rxc > 0;
    bit restart;
    int rt = rx_level(m_lvl[5:3]);
    int tt = tx_level(m_lvl[2:0]);
    logic [6:0] s = '0, c = '0;
    if (rx_push) begin
      if (rxc < 16) begin
        m_rxq.push_back({m_ovr, rx_err, rx_data});
        m_ovr = 0;
        s[3] = rx_err[0]; s[4] = rx_err[1]; s[5] = rx_err[2];
      end else begin
        s[6] = 1'b1; m_ovr = 1;
      end
    end
    if (rdpop) void'(m_rxq.pop_front());
    if (rxc < rt && m_rxq.size() >= rt) s[0] = 1'b1;
    if (bus_sel && bus_wr && bus_addr[4:2] == 3'd0 && txc < 16) m_txq.push_back(bus_wdata[7:0]);
    if (tx_pop && txc > 0) void'(m_txq.pop_front());
    if (txc > tt && m_txq.size() <= tt) s[1] = 1'b1;
    restart = rx_push || rdpop;
    if (!restart && rxc != 0 && bit_tick && m_idle == 31) s[2] = 1'b1;
    if (restart || rxc == 0) m_idle = 0;
    else if (bit_tick && m_idle != 32) m_idle++;
    if (bus_sel && bus_wr) begin
      if (bus_addr[4:2] == 3'd2) m_lvl  = bus_wdata[5:0];
      if (bus_addr[4:2] == 3'd3) m_mask = bus_wdata[10:4];
      if (bus_addr[4:2] == 3'd6) c      = bus_wdata[10:4];
    end
    m_raw = (m_raw & ~c) | s;
  endtask

  task automatic tick(input string tag);
    #1;
    chk("R9 irq", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
    chk("R10 tx_valid", {31'd0, tx_valid}, {31'd0, m_txq.size() != 0});
    if (tx_pop && m_txq.size() != 0) chk("R10 tx_data", {24'd0, tx_data}, {24'd0, m_txq[0]});
    if (bus_sel && !bus_wr) chk(tag, bus_rdata, expect_read(bus_addr[4:2]));
    @(posedge clk);
    model_step();
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    tx_pop = 0; rx_push = 0; rx_err = '0; rx_data = '0; bit_tick = 0;
  endtask

  task automatic rd(input logic [2:0] ofs, input string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = {ofs, 2'b00};
    tick(tag);
  endtask

  task automatic wr(input logic [2:0] ofs, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = {ofs, 2'b00}; bus_wdata = d;
    tick("write");
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] e);
    rx_push = 1; rx_data = d; rx_err = e;
    tick("push");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(3'd1, "R11 R2 status after reset");
    rd(3'd4, "R11 raw after reset");
    rd(3'd2, "R11 level after reset");
    tx_busy = 1; rd(3'd1, "R2 busy from tx_busy"); tx_busy = 0;

    wr(3'd3, 32'h7F0);
    wr(3'd2, 32'h12);
    for (int i = 0; i < 16; i++) push(8'h30 + 8'(i), 3'(i % 8));
    rd(3'd4, "R3 R7 raw after fill");
    rd(3'd1, "R2 rx full");
    push(8'hEE, 3'd0);
    rd(3'd4, "R6 overrun flag");
    rd(3'd0, "R1 first entry");
    push(8'h5A, 3'd0);
    for (int i = 0; i < 17; i++) rd(3'd0, "R1 R6 drain order");
    rd(3'd1, "R2 rx empty");

    wr(3'd6, 32'h7F0);
    rd(3'd4, "R8 full clear");
    push(8'h11, 3'd0);
    for (int i = 0; i < 31; i++) begin bit_tick = 1; tick("idle"); end
    rd(3'd4, "R5 not yet idle");
    bit_tick = 1; tick("idle");
    rd(3'd4, "R5 idle flag");
    wr(3'd6, 32'h0);
    rd(3'd4, "R8 zero write no effect");
    wr(3'd6, 32'h040);
    rd(3'd4, "R8 single bit clear");
    rd(3'd0, "R1 drain");
    for (int i = 0; i < 40; i++) begin bit_tick = 1; tick("idle empty"); end
    rd(3'd4, "R5 no flag when empty");

    for (int code = 0; code < 8; code++) begin
      wr(3'd6, 32'h7F0);
      wr(3'd2, 32'((code << 3) | code));
      for (int i = 0; i < 16; i++) begin
        push(8'(i * 7), 3'd0);
        rd(3'd4, "R3 rx crossing");
      end
      for (int i = 0; i < 16; i++) begin
        bus_sel = 1; bus_wr = 1; bus_addr = 5'd0; bus_wdata = 32'(i + code);
        tick("tx write");
      end
      wr(3'd0, 32'hFF);
      rd(3'd1, "R10 R2 tx full");
      for (int i = 0; i < 16; i++) begin
        tx_pop = 1; tick("pop");
        rd(3'd4, "R4 tx crossing");
      end
      tx_pop = 1; tick("R10 pop empty");
      for (int i = 0; i < 16; i++) rd(3'd0, "R1 drain");
    end

    wr(3'd2, 32'h12);
    for (int n = 0; n < 6000; n++) begin
      int r = $urandom_range(0, 99);
      rx_push  = ($urandom_range(0, 99) < 30);
      rx_data  = 8'($urandom);
      rx_err   = ($urandom_range(0, 9) == 0) ? 3'($urandom) : 3'd0;
      tx_pop   = ($urandom_range(0, 99) < 30);
      tx_busy  = ($urandom_range(0, 3) == 0);
      bit_tick = ($urandom_range(0, 99) < 40);
      if (r < 25) begin bus_sel = 1; bus_wr = 0; bus_addr = 5'd0; end
      else if (r < 55) begin bus_sel = 1; bus_wr = 1; bus_addr = 5'd0; bus_wdata = $urandom; end
      else if (r < 75) begin bus_sel = 1; bus_wr = 0; bus_addr = {3'($urandom), 2'b00}; end
      else if (r < 78) begin bus_sel = 1; bus_wr = 1; bus_addr = 5'h08; bus_wdata = $urandom; end
      else if (r < 81) begin bus_sel = 1; bus_wr = 1; bus_addr = 5'h0C; bus_wdata = $urandom; end
      else if (r < 86) begin bus_sel = 1; bus_wr = 1; bus_addr = 5'h18; bus_wdata = $urandom; end
      tick("R1 R2 R9 random read");
    end
    tx_busy = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule